// File: doc/BRIEF.md
# Multi-Cycle Integer Execution Unit

This block is the integer execute stage of a small 32-bit core. A 3-bit operation code picks the kind of work: bitwise logic, shifting, comparison, addition or subtraction, multiplication, division or remainder. A 2-bit option field chooses the variant within that kind. Logic, shift, compare and add/sub results appear combinationally in the same cycle as their operands.

Multiplication, division and remainder run on iterative sub-units that each take one bit per clock. When such an operation is issued, the unit raises its stall output in that same cycle and keeps it high until the sub-unit reports completion. The finished value is then held in a result register. Division and remainder share a single divider. A stall input from the rest of the core stops new long operations from starting. A floating-point select input is present but is not implemented: while it is high, the unit returns zero and never stalls.

Top module: `exec_unit`

## Requirements
- R1: With opMode 0 (idle) and fpSel low, result is zero and stallOut is low. Both also hold while reset is asserted.
- R2: opMode 1 (logic) returns A AND B for opOpt 0, A OR B for opOpt 1, A XOR B for opOpt 2, and zero for opOpt 3.
- R3: opMode 2 (shift) shifts A by B[4:0]. opOpt[1] selects the direction (0 left, 1 right). opOpt[0] selects the fill for right shifts (0 zero fill, 1 sign fill). A left shift is the same for either opOpt[0] value.
- R4: opMode 3 (compare) returns 1 or 0. opOpt 0 tests signed A<B, opOpt 1 tests unsigned A<B, opOpt 2 tests A==B, and opOpt 3 tests A!=B.
- R5: opMode 4 returns A+B when opOpt[0] is 0 and A-B when opOpt[0] is 1, wrapping modulo 2^32.
- R6: opMode 5 returns the low 32 bits of the signed product A*B.
- R7: opMode 6 returns the signed quotient truncated toward zero. opMode 7 returns the remainder, which takes the sign of the dividend.
- R8: When the divisor is zero, the quotient is all ones and the remainder equals the dividend. For the most negative value divided by -1, the quotient equals the dividend and the remainder is zero.
- R9: A long operation (opMode 5, 6 or 7) raises stallOut in its issue cycle. stallOut stays high for exactly 34 consecutive cycles. The result is presented in the first cycle in which stallOut is low.
- R10: While stallIn is high, no long operation starts (stallOut stays low) and the result of a long opMode holds the last completed value.
- R11: While fpSel is high, result is zero and stallOut is low, for any opMode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| opMode | input | 3 | Operation kind: 0 idle, 1 logic, 2 shift, 3 compare, 4 add/sub, 5 mul, 6 div, 7 rem |
| opOpt | input | 2 | Variant within the operation kind |
| fpSel | input | 1 | Floating-point select; forces a zero result |
| stallIn | input | 1 | Core freeze; blocks issue of long operations |
| stallOut | output | 1 | High while a long operation is in flight |
| operandA | input | 32 | First operand |
| operandB | input | 32 | Second operand |
| result | output | 32 | Operation result |

## Verification
Single-cycle results are due in the same cycle that their operands are driven. The bench samples them just before the next rising edge and expects no stall. A long operation is due in the first low-stall cycle after a run of 34 stall cycles. The scoreboard monitor counts the stalled cycles at each mid-cycle sample and then compares both the count and the value. Stall-in behaviour is sampled over several cycles to confirm that no issue happens and that the held value persists.

// File: rtl/exec_pkg.sv
package exec_pkg;

  localparam logic [2:0] MODE_IDLE  = 3'd0;
  localparam logic [2:0] MODE_LOGIC = 3'd1;
  localparam logic [2:0] MODE_SHIFT = 3'd2;
  localparam logic [2:0] MODE_CMP   = 3'd3;
  localparam logic [2:0] MODE_ADD   = 3'd4;
  localparam logic [2:0] MODE_MUL   = 3'd5;
  localparam logic [2:0] MODE_DIV   = 3'd6;
  localparam logic [2:0] MODE_REM   = 3'd7;

  typedef enum logic [1:0] {
    CAP_PROD = 2'd0,
    CAP_QUOT = 2'd1,
    CAP_REM  = 2'd2
  } cap_sel_e;

  typedef struct packed {
    logic     startMul;
    logic     startDiv;
    logic     capture;
    cap_sel_e capSel;
    logic     showHold;
  } ctrl_strobe_t;

endpackage

// File: rtl/exec_mul.sv
module exec_mul #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             doneOut,
  output logic [WIDTH-1:0] prodOut
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] acc, mcand, mplier;
  logic [CW-1:0]    cnt;
  logic             busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc     <= '0;
      mcand   <= '0;
      mplier  <= '0;
      cnt     <= '0;
      busy    <= 1'b0;
      doneOut <= 1'b0;
    end else begin
      doneOut <= 1'b0;
      if (startIn) begin
        acc    <= '0;
        mcand  <= a;
        mplier <= b;
        cnt    <= CW'(WIDTH);
        busy   <= 1'b1;
      end else if (busy) begin
        if (mplier[0]) acc <= acc + mcand;
        mcand  <= mcand << 1;
        mplier <= mplier >> 1;
        cnt    <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy    <= 1'b0;
          doneOut <= 1'b1;
        end
      end
    end
  end

  assign prodOut = acc;
endmodule

// File: rtl/exec_div.sv
module exec_div #(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startIn,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             doneOut,
  output logic [WIDTH-1:0] quotOut,
  output logic [WIDTH-1:0] remOut
);
  localparam int CW = $clog2(WIDTH + 1);

  logic [WIDTH-1:0] quo, rem, dvs, dividend;
  logic [WIDTH:0]   partial;
  logic [CW-1:0]    cnt;
  logic             busy, negQ, negR, zeroDiv;

  assign partial = {rem, quo[WIDTH-1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quo      <= '0;
      rem      <= '0;
      dvs      <= '0;
      dividend <= '0;
      cnt      <= '0;
      busy     <= 1'b0;
      negQ     <= 1'b0;
      negR     <= 1'b0;
      zeroDiv  <= 1'b0;
      doneOut  <= 1'b0;
    end else begin
      doneOut <= 1'b0;
      if (startIn) begin
        quo      <= a[WIDTH-1] ? -a : a;
        dvs      <= b[WIDTH-1] ? -b : b;
        rem      <= '0;
        dividend <= a;
        negQ     <= a[WIDTH-1] ^ b[WIDTH-1];
        negR     <= a[WIDTH-1];
        zeroDiv  <= (b == '0);
        cnt      <= CW'(WIDTH);
        busy     <= 1'b1;
      end else if (busy) begin
        if (partial >= {1'b0, dvs}) begin
          rem <= WIDTH'(partial - {1'b0, dvs});
          quo <= {quo[WIDTH-2:0], 1'b1};
        end else begin
          rem <= partial[WIDTH-1:0];
          quo <= {quo[WIDTH-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          busy    <= 1'b0;
          doneOut <= 1'b1;
        end
      end
    end
  end

  assign quotOut = zeroDiv ? '1 : (negQ ? -quo : quo);
  assign remOut  = zeroDiv ? dividend : (negR ? -rem : rem);
endmodule

// File: rtl/exec_ctrl.sv
module exec_ctrl
  import exec_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [2:0]   opMode,
  input  logic         fpSel,
  input  logic         stallIn,
  input  logic         unitValid,
  output ctrl_strobe_t strobe,
  output logic         stallOut
);
  typedef enum logic [1:0] {ST_IDLE, ST_BUSY, ST_DONE} state_e;

  state_e   state;
  cap_sel_e kindReg;
  logic     isLong, startOp;

  assign isLong  = !fpSel && (opMode >= MODE_MUL);
  assign startOp = (state == ST_IDLE) && isLong && !stallIn;

  always_comb begin
    strobe.startMul = startOp && (opMode == MODE_MUL);
    strobe.startDiv = startOp && (opMode != MODE_MUL);
    strobe.capture  = (state == ST_BUSY) && unitValid;
    strobe.capSel   = kindReg;
    strobe.showHold = isLong;
  end

  assign stallOut = startOp || (state == ST_BUSY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      kindReg <= CAP_PROD;
    end else begin
      unique case (state)
        ST_IDLE: if (startOp) begin
          state   <= ST_BUSY;
          kindReg <= (opMode == MODE_MUL) ? CAP_PROD :
                     (opMode == MODE_DIV) ? CAP_QUOT : CAP_REM;
        end
        ST_BUSY: if (unitValid) state <= ST_DONE;
        ST_DONE: if (!stallIn)  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
  import exec_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strobe,
  input  logic [2:0]       opMode,
  input  logic [1:0]       opOpt,
  input  logic             fpSel,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic             unitValid,
  output logic [WIDTH-1:0] result
);
  localparam int SW = $clog2(WIDTH);

  logic [WIDTH-1:0] prod, quot, remd, holdReg, quick;
  logic             mulDone, divDone, cmpBit;
  logic [SW-1:0]    shAmt;

  exec_mul #(.WIDTH(WIDTH)) u_mul (
    .clk(clk), .rstN(rstN), .startIn(strobe.startMul),
    .a(a), .b(b), .doneOut(mulDone), .prodOut(prod)
  );

  exec_div #(.WIDTH(WIDTH)) u_div (
    .clk(clk), .rstN(rstN), .startIn(strobe.startDiv),
    .a(a), .b(b), .doneOut(divDone), .quotOut(quot), .remOut(remd)
  );

  assign unitValid = mulDone || divDone;
  assign shAmt     = b[SW-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdReg <= '0;
    else if (strobe.capture) begin
      unique case (strobe.capSel)
        CAP_QUOT: holdReg <= quot;
        CAP_REM:  holdReg <= remd;
        default:  holdReg <= prod;
      endcase
    end
  end

  always_comb begin
    unique case (opOpt)
      2'd0:    cmpBit = $signed(a) < $signed(b);
      2'd1:    cmpBit = a < b;
      2'd2:    cmpBit = a == b;
      default: cmpBit = a != b;
    endcase
  end

  always_comb begin
    quick = '0;
    case (opMode)
      MODE_LOGIC: begin
        unique case (opOpt)
          2'd0:    quick = a & b;
          2'd1:    quick = a | b;
          2'd2:    quick = a ^ b;
          default: quick = '0;
        endcase
      end
      MODE_SHIFT: begin
        if (!opOpt[1])     quick = a << shAmt;
        else if (opOpt[0]) quick = $signed(a) >>> shAmt;
        else               quick = a >> shAmt;
      end
      MODE_CMP: quick = {{(WIDTH-1){1'b0}}, cmpBit};
      MODE_ADD: quick = opOpt[0] ? a - b : a + b;
      default:  quick = '0;
    endcase
  end

  assign result = fpSel ? '0 : (strobe.showHold ? holdReg : quick);
endmodule

// File: rtl/exec_unit.sv
module exec_unit
  import exec_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       opMode,
  input  logic [1:0]       opOpt,
  input  logic             fpSel,
  input  logic             stallIn,
  output logic             stallOut,
  input  logic [WIDTH-1:0] operandA,
  input  logic [WIDTH-1:0] operandB,
  output logic [WIDTH-1:0] result
);
  ctrl_strobe_t strobe;
  logic         unitValid;

  exec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opMode(opMode), .fpSel(fpSel),
    .stallIn(stallIn), .unitValid(unitValid), .strobe(strobe),
    .stallOut(stallOut)
  );

  exec_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opMode(opMode),
    .opOpt(opOpt), .fpSel(fpSel), .a(operandA), .b(operandB),
    .unitValid(unitValid), .result(result)
  );
endmodule

// File: rtl/exec_unit_chk.sv
module exec_unit_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       opMode,
  input logic             fpSel,
  input logic             stallIn,
  input logic             stallOut,
  input logic [WIDTH-1:0] result
);
  localparam int LAT = WIDTH + 2;

  int runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= 0;
    else       runLen <= stallOut ? runLen + 1 : 0;
  end

  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (opMode == 3'd0 && !fpSel) |-> (result == '0 && !stallOut));

  // R11
  fp_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    fpSel |-> (result == '0 && !stallOut));

  // R9
  stall_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stallOut && runLen != 0) |-> (runLen == LAT));

  // R9
  stall_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    stallOut |-> (runLen < LAT));

  // R10
  no_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stallIn && !$past(stallOut)) |-> !stallOut);

  // R10
  hold_result_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stallIn && $past(stallIn) && !fpSel && !$past(fpSel) &&
     opMode >= 3'd5 && $past(opMode) >= 3'd5 && !$past(stallOut))
    |-> $stable(result));
endmodule

bind exec_unit exec_unit_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .opMode(opMode), .fpSel(fpSel),
  .stallIn(stallIn), .stallOut(stallOut), .result(result)
);

// File: tb/test_exec_unit.sv
module test_exec_unit;
  localparam int W   = 32;
  localparam int LAT = W + 2;
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  logic         clk = 1'b0;
  logic         rstN;
  logic [2:0]   opMode;
  logic [1:0]   opOpt;
  logic         fpSel, stallIn, stallOut;
  logic [W-1:0] operandA, operandB, result;

  always #4 clk = ~clk;

  exec_unit #(.WIDTH(W)) i_exec_unit (
    .clk(clk), .rstN(rstN), .opMode(opMode), .opOpt(opOpt), .fpSel(fpSel),
    .stallIn(stallIn), .stallOut(stallOut), .operandA(operandA),
    .operandB(operandB), .result(result)
  );

  typedef struct {
    logic [W-1:0] expVal;
    int           expLat;
    string        tag;
  } item_t;

  item_t sbQ[$];
  int issued = 0, completed = 0, checks = 0, failures = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, got, exp);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  function automatic logic [W-1:0] model(input logic [2:0] m, input logic [1:0] o,
                                         input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic fp);
    logic [W-1:0] r;
    if (fp) return '0;
    case (m)
      3'd1: r = (o == 2'd0) ? (a & b) : (o == 2'd1) ? (a | b) :
                (o == 2'd2) ? (a ^ b) : '0;
      3'd2: begin
        if (!o[1])     r = a << b[4:0];
        else if (o[0]) r = $signed(a) >>> b[4:0];
        else           r = a >> b[4:0];
      end
      3'd3: begin
        r = '0;
        case (o)
          2'd0: r[0] = $signed(a) < $signed(b);
          2'd1: r[0] = a < b;
          2'd2: r[0] = a == b;
          default: r[0] = a != b;
        endcase
      end
      3'd4: r = o[0] ? a - b : a + b;
      3'd5: r = a * b;
      3'd6: begin
        if (b == '0)                   r = '1;
        else if (a == MINV && b == '1) r = a;
        else                           r = $signed(a) / $signed(b);
      end
      3'd7: begin
        if (b == '0)                   r = a;
        else if (a == MINV && b == '1) r = '0;
        else                           r = $signed(a) % $signed(b);
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  task automatic issue(input logic [2:0] m, input logic [1:0] o,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic fp, input string tag);
    item_t it;
    @(negedge clk);
    opMode = m; opOpt = o; operandA = a; operandB = b; fpSel = fp; stallIn = 1'b0;
    it.expVal = model(m, o, a, b, fp);
    it.expLat = (!fp && m >= 3'd5) ? LAT : 0;
    it.tag    = tag;
    sbQ.push_back(it);
    issued++;
    wait (completed == issued);
  endtask

  // monitor: pops expected items and compares at mid-cycle
  initial begin
    item_t it;
    int n;
    forever begin
      wait (completed < issued);
      it = sbQ.pop_front();
      #2;
      n = 0;
      while (stallOut && n < LAT + 10) begin
        n++;
        @(negedge clk);
        #2;
      end
      check(result === it.expVal, it.tag, "result", result, it.expVal);
      check(n == it.expLat, it.tag, "stall cycles", W'(n), W'(it.expLat));
      completed++;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic [W-1:0] held;
    rstN = 1'b0; opMode = 3'd0; opOpt = 2'd0; fpSel = 1'b0; stallIn = 1'b0;
    operandA = '0; operandB = '0;
    repeat (3) @(negedge clk);
    #2;
    // R1 reset state
    check(result == '0, "R1", "reset result", result, '0);
    check(!stallOut, "R1", "reset stall", W'(stallOut), '0);
    @(negedge clk);
    rstN = 1'b1;

    // R10: stall-in blocks issue before any long op has completed
    opMode = 3'd6; operandA = 32'd100; operandB = 32'd7; stallIn = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #2;
      check(!stallOut, "R10", "no issue", W'(stallOut), '0);
      check(result == '0, "R10", "held zero", result, '0);
    end

    issue(3'd0, 2'd1, 32'hDEAD_BEEF, 32'h1234_5678, 1'b0, "R1");
    // R2 logic
    issue(3'd1, 2'd0, 32'hF0F0_1234, 32'hFF00_FF0F, 1'b0, "R2");
    issue(3'd1, 2'd1, 32'hF0F0_1234, 32'h0F00_FF0F, 1'b0, "R2");
    issue(3'd1, 2'd2, 32'hAAAA_5555, 32'hFFFF_0000, 1'b0, "R2");
    issue(3'd1, 2'd3, 32'hAAAA_5555, 32'hFFFF_0000, 1'b0, "R2");
    // R3 shift
    issue(3'd2, 2'd0, 32'h8000_0F01, 32'd4, 1'b0, "R3");
    issue(3'd2, 2'd1, 32'h8000_0F01, 32'd31, 1'b0, "R3");
    issue(3'd2, 2'd2, 32'h8000_0F00, 32'd8, 1'b0, "R3");
    issue(3'd2, 2'd3, 32'h8000_0F00, 32'd8, 1'b0, "R3");
    issue(3'd2, 2'd3, 32'h8000_0000, 32'hFFFF_FFE0, 1'b0, "R3");
    // R4 compare
    issue(3'd3, 2'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, "R4");
    issue(3'd3, 2'd1, 32'hFFFF_FFFF, 32'd1, 1'b0, "R4");
    issue(3'd3, 2'd2, 32'd77, 32'd77, 1'b0, "R4");
    issue(3'd3, 2'd3, 32'd77, 32'd77, 1'b0, "R4");
    // R5 add/sub
    issue(3'd4, 2'd0, 32'h7FFF_FFFF, 32'd1, 1'b0, "R5");
    issue(3'd4, 2'd1, 32'd5, 32'd9, 1'b0, "R5");
    // R6 multiply
    issue(3'd5, 2'd0, 32'hFFFF_FFFD, 32'd7, 1'b0, "R6");
    issue(3'd5, 2'd0, 32'h1234_5678, 32'h9ABC_DEF1, 1'b0, "R6");
    // R7 divide / remainder
    issue(3'd6, 2'd0, 32'hFFFF_FFF9, 32'd2, 1'b0, "R7");
    issue(3'd7, 2'd0, 32'hFFFF_FFF9, 32'd2, 1'b0, "R7");
    issue(3'd6, 2'd0, 32'd7, 32'hFFFF_FFFE, 1'b0, "R7");
    issue(3'd7, 2'd0, 32'd7, 32'hFFFF_FFFE, 1'b0, "R7");
    issue(3'd6, 2'd0, 32'd1000, 32'd101, 1'b0, "R7");
    // R8 corners
    issue(3'd6, 2'd0, 32'd1234, 32'd0, 1'b0, "R8");
    issue(3'd7, 2'd0, 32'hFFFF_FF00, 32'd0, 1'b0, "R8");
    issue(3'd6, 2'd0, MINV, 32'hFFFF_FFFF, 1'b0, "R8");
    issue(3'd7, 2'd0, MINV, 32'hFFFF_FFFF, 1'b0, "R8");
    // R9 back-to-back long ops
    issue(3'd5, 2'd0, 32'd3, 32'd5, 1'b0, "R9");
    issue(3'd5, 2'd0, 32'd11, 32'd13, 1'b0, "R9");
    // R11 floating point select
    issue(3'd5, 2'd0, 32'd3, 32'd5, 1'b1, "R11");
    issue(3'd4, 2'd0, 32'd3, 32'd5, 1'b1, "R11");

    // R10: result holds the last completed value while stall-in is high
    held = model(3'd6, 2'd0, 32'd200, 32'd9, 1'b0);
    issue(3'd6, 2'd0, 32'd200, 32'd9, 1'b0, "R10");
    @(negedge clk);
    opMode = 3'd5; operandA = 32'd4; operandB = 32'd4; stallIn = 1'b1;
    for (int k = 0; k < 4; k++) begin
      #2;
      check(!stallOut, "R10", "no issue", W'(stallOut), '0);
      check(result == held, "R10", "held result", result, held);
      @(negedge clk);
    end
    issue(3'd7, 2'd0, 32'd200, 32'd9, 1'b0, "R10");

    @(negedge clk);
    opMode = 3'd0;
    repeat (2) @(negedge clk);
    finishRun();
  end
endmodule